// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block owns a small identification page that sits beside the main memory array of a serial two-wire EEPROM. The bus front end decodes the Start and Stop conditions, the select byte, the two address bytes, the incoming data bytes and the requests for outgoing read bytes. It hands each of these to this block as a single-cycle event. The block decides whether each byte is acknowledged. It collects write data in a staging buffer and copies it into the page during a busy period that follows the committing Stop. It returns read bytes from a pointer that wraps inside the page.

A one-time lock flag makes the page permanently read-only. Software sets it with a byte-write-shaped command that has address bit 10 set and data bit 1 set. The flag takes effect at the end of the busy period that follows the committing Stop. Once the page is locked, every data byte of an identification write is refused and reads return all ones. A host can probe the lock state without changing it: it sends an identification write with one data byte, reads the acknowledge, then issues a new Start to abandon the command. The only way to clear the flag is reset, which stands in for its nonvolatile retention.

Top module: `idpage_lockable`

## Requirements
- R1: A select event whose type field is 4'b1011 is acknowledged while the block is idle. A select with any other type field produces no acknowledge event and ends any open transaction.
- R2: While busy, an identification select produces an acknowledge event with acknowledge low, and it opens no transaction.
- R3: In a write transaction whose address has bit 10 = 0, bits 6:0 give the first byte offset and the other address bits are ignored. Each acknowledged data byte goes to the next offset, wrapping from 127 to 0. A Stop after at least one accepted data byte starts a busy period of BUSY_CYC cycles, and the page holds the new bytes after it ends.
- R4: A Start that arrives before the Stop abandons a write. Nothing is written and no busy period starts.
- R5: In a write transaction whose address has bit 10 = 1, the first data byte is the lock command. If its bit 1 is 1, the lock flag sets at the end of the busy period that follows the Stop, not earlier. If bit 1 is 0, the flag stays clear.
- R6: Once locked, every data byte of an identification write gets acknowledge low. The page and the flag do not change and no busy period starts. The flag never clears except by reset.
- R7: While locked, every identification read byte is 8'hFF.
- R8: A read transaction returns the byte at the pointer loaded from address bits 6:0 of the preceding write-form address. Each byte read advances the pointer, wrapping from 127 to 0.
- R9: After reset every page byte reads 8'hFF, the lock flag is clear and busy is low.
- R10: Both address bytes of an identification write are acknowledged whether or not the page is locked.
- R11: A lock probe returns acknowledge high on its data byte when the page is unlocked and acknowledge low when it is locked. If a Start follows, the lock state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start or repeated Start seen on the bus |
| sel_vld | input | 1 | Select byte received |
| sel_type | input | 4 | Type field of the select byte |
| sel_rnw | input | 1 | Direction bit of the select byte, 1 = read |
| addr_vld | input | 1 | Both address bytes received |
| addr | input | AW | 16-bit byte address |
| wr_vld | input | 1 | Data byte received in a write |
| wr_data | input | DW | Received data byte |
| rd_req | input | 1 | Front end requests the next read byte |
| stop | input | 1 | Stop condition seen on the bus |
| ack_vld | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_vld | output | 1 | Read byte is valid |
| rd_data | output | DW | Read byte |
| busy | output | 1 | Commit cycle in progress |
| locked | output | 1 | Lock flag |

## Verification
The embedded assertions check, on every cycle, the rules that hold locally. An identification select during busy is refused. Address bytes are always acknowledged. Locked data bytes are refused. The lock flag never falls, and it rises only at the edge where busy falls. Read bytes are all ones while locked. What only the scenarios can show is the end-to-end data path: staged bytes landing at the right wrapped offsets after the busy period, a Start discarding a staged write, upper address bits being ignored, and a lock probe leaving the flag untouched. A behavioural model in the bench follows the page contents and pointer and checks these against the ports on every clock.

// File: rtl/idp_pkg.sv
package idp_pkg;
  // Type field in the select byte that addresses the identification page
  localparam logic [3:0] ID_TYPE = 4'b1011;
  // Address bit that separates page writes (0) from the lock command (1)
  localparam int LOCK_ADDR_BIT = 10;
  // Data bit that must be set for the lock command to take effect
  localparam int LOCK_DATA_BIT = 1;
endpackage

// File: rtl/idp_stage.sv
module idp_stage #(
  parameter int PAGE = 128,
  parameter int DW   = 8,
  localparam int PW  = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rhit
);
  logic [DW-1:0]   buf_q [PAGE];
  logic [PAGE-1:0] vmask_q;

  always_ff @(posedge clk) begin
    if (we) buf_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vmask_q <= '0;
    else if (we)    vmask_q[waddr] <= 1'b1;
  end

  assign rdata = buf_q[raddr];
  assign rhit  = vmask_q[raddr];
endmodule

// File: rtl/idp_store.sv
module idp_store #(
  parameter int PAGE = 128,
  parameter int DW   = 8,
  localparam int PW  = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [PW-1:0] raddr,
  input  logic          force_ff,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]   mem_q [PAGE];
  logic [PAGE-1:0] written_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      rd_vld    <= 1'b0;
      rd_data   <= '1;
    end else begin
      if (we) written_q[waddr] <= 1'b1;
      rd_vld <= rd_en;
      if (rd_en)
        rd_data <= (force_ff || !written_q[raddr]) ? '1 : mem_q[raddr];
    end
  end

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    rd_en && force_ff |=> rd_vld && (rd_data == {DW{1'b1}})); // R7
endmodule

// File: rtl/idp_ctrl.sv
module idp_ctrl
  import idp_pkg::*;
#(
  parameter int PAGE     = 128,
  parameter int DW       = 8,
  parameter int AW       = 16,
  parameter int BUSY_CYC = 160,   // must be at least PAGE
  localparam int PW      = $clog2(PAGE),
  localparam int CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sel_vld,
  input  logic [3:0]    sel_type,
  input  logic          sel_rnw,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          wr_vld,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          stop,
  output logic          ack_vld,
  output logic          ack,
  output logic          busy,
  output logic          locked,
  output logic          stg_clr,
  output logic          stg_we,
  output logic [PW-1:0] stg_waddr,
  output logic [PW-1:0] stg_raddr,
  input  logic          stg_rhit,
  output logic          str_we,
  output logic [PW-1:0] str_waddr,
  output logic          rd_en,
  output logic [PW-1:0] rd_addr
);
  localparam logic [CW-1:0] LAST  = CW'(BUSY_CYC - 1);
  localparam logic [CW-1:0] PAGEC = CW'(PAGE);

  logic          active, rnw, islock, have, lockpend;
  logic [PW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic          id_sel, addr_go, wr_go, rd_go;

  assign id_sel  = sel_vld && (sel_type == ID_TYPE);
  assign addr_go = addr_vld && active && !rnw;
  assign wr_go   = wr_vld && active && !rnw;
  assign rd_go   = rd_req && active && rnw;

  // staging and commit walk
  assign stg_clr   = addr_go || (start && !busy);
  assign stg_we    = wr_go && !locked && !islock;
  assign stg_waddr = ptr;
  assign stg_raddr = cnt[PW-1:0];
  assign str_we    = busy && (cnt < PAGEC) && stg_rhit;
  assign str_waddr = cnt[PW-1:0];
  assign rd_en     = rd_go;
  assign rd_addr   = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; rnw <= 1'b0; islock <= 1'b0; have <= 1'b0;
      lockpend <= 1'b0; busy <= 1'b0; locked <= 1'b0;
      cnt <= '0; ptr <= '0; ack_vld <= 1'b0; ack <= 1'b0;
    end else begin
      ack_vld <= 1'b0;
      ack     <= 1'b0;
      if (busy) begin
        if (cnt == LAST) begin
          busy     <= 1'b0;
          cnt      <= '0;
          lockpend <= 1'b0;
          if (lockpend) locked <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (start) begin
        active <= 1'b0;
        have   <= 1'b0;
        if (!busy) lockpend <= 1'b0;
      end
      if (id_sel) begin
        ack_vld <= 1'b1;
        ack     <= !busy;
        active  <= !busy;
        rnw     <= sel_rnw;
        if (!busy) begin
          have     <= 1'b0;
          lockpend <= 1'b0;
        end
      end else if (sel_vld) begin
        active <= 1'b0;
      end
      if (addr_go) begin
        ack_vld <= 1'b1;
        ack     <= 1'b1;
        ptr     <= addr[PW-1:0];
        islock  <= addr[LOCK_ADDR_BIT];
      end
      if (wr_go) begin
        ack_vld <= 1'b1;
        ack     <= !locked;
        if (!locked) begin
          have <= 1'b1;
          if (islock) begin
            if (!have) lockpend <= wr_data[LOCK_DATA_BIT];
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
      end
      if (rd_go) ptr <= ptr + 1'b1;
      if (stop) begin
        active <= 1'b0;
        if (active && !rnw && have) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end
    end
  end

  AST_BUSY_SELECT_NACK: assert property (@(posedge clk) disable iff (rst)
    id_sel && busy |=> ack_vld && !ack); // R2
  AST_ADDR_ALWAYS_ACK: assert property (@(posedge clk) disable iff (rst)
    addr_go |=> ack_vld && ack); // R10
  AST_LOCKED_DATA_NACK: assert property (@(posedge clk) disable iff (rst)
    wr_go && locked |=> ack_vld && !ack); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R6
  AST_LOCK_AT_COMMIT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $fell(busy)); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= LAST); // R3
endmodule

// File: rtl/idpage_lockable.sv
module idpage_lockable #(
  parameter int PAGE     = 128,
  parameter int DW       = 8,
  parameter int AW       = 16,
  parameter int BUSY_CYC = 160,
  localparam int PW      = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sel_vld,
  input  logic [3:0]    sel_type,
  input  logic          sel_rnw,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          wr_vld,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          stop,
  output logic          ack_vld,
  output logic          ack,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          locked
);
  logic          stg_clr, stg_we, stg_rhit, str_we, rd_en;
  logic [PW-1:0] stg_waddr, stg_raddr, str_waddr, rd_addr;
  logic [DW-1:0] stg_rdata;

  idp_ctrl #(.PAGE(PAGE), .DW(DW), .AW(AW), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk, .rst, .start, .sel_vld, .sel_type, .sel_rnw, .addr_vld, .addr,
    .wr_vld, .wr_data, .rd_req, .stop, .ack_vld, .ack, .busy, .locked,
    .stg_clr, .stg_we, .stg_waddr, .stg_raddr, .stg_rhit,
    .str_we, .str_waddr, .rd_en, .rd_addr
  );

  idp_stage #(.PAGE(PAGE), .DW(DW)) u_stage (
    .clk, .rst, .clr(stg_clr), .we(stg_we), .waddr(stg_waddr),
    .wdata(wr_data), .raddr(stg_raddr), .rdata(stg_rdata), .rhit(stg_rhit)
  );

  idp_store #(.PAGE(PAGE), .DW(DW)) u_store (
    .clk, .rst, .we(str_we), .waddr(str_waddr), .wdata(stg_rdata),
    .rd_en, .raddr(rd_addr), .force_ff(locked), .rd_vld, .rd_data
  );
endmodule

// File: tb/idpage_lockable_test.sv
`timescale 1ns/1ps
module idpage_lockable_test;
  localparam int BUSY_CYC = 160;
  localparam logic [3:0] IDT = 4'b1011;

  logic clk = 0, rst = 1;
  logic start = 0, sel_vld = 0, sel_rnw = 0, addr_vld = 0, wr_vld = 0, rd_req = 0, stop = 0;
  logic [3:0]  sel_type = '0;
  logic [15:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic ack_vld, ack, rd_vld, busy, locked;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  string cur = "R9";

  always #2.5 clk = ~clk;

  idpage_lockable uut (
    .clk, .rst, .start, .sel_vld, .sel_type, .sel_rnw, .addr_vld, .addr,
    .wr_vld, .wr_data, .rd_req, .stop, .ack_vld, .ack, .rd_vld, .rd_data,
    .busy, .locked
  );

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_mem [128];
  bit  m_wr  [128];
  int  m_stg [128];
  bit  m_stv [128];
  int  pend_off[$];
  int  pend_dat[$];
  bit  m_active, m_rnw, m_islock, m_have, m_lockpend, m_locked, m_go;
  int  m_ptr, m_left;
  bit  e_ackv, e_ack, e_rdv;
  int  e_rd;

  always @(posedge clk) begin
    bit bz;
    if (rst) begin
      foreach (m_wr[i]) begin m_wr[i] = 0; m_stv[i] = 0; end
      m_active = 0; m_rnw = 0; m_islock = 0; m_have = 0; m_lockpend = 0;
      m_locked = 0; m_ptr = 0; m_left = 0; e_ackv = 0; e_ack = 0; e_rdv = 0; e_rd = 255;
      pend_off.delete(); pend_dat.delete(); m_go = 1;
    end else begin
      bz = (m_left > 0);
      e_ackv = 0; e_ack = 0; e_rdv = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          while (pend_off.size() > 0) begin
            int o, d;
            o = pend_off.pop_front(); d = pend_dat.pop_front();
            m_mem[o] = d; m_wr[o] = 1;
          end
          if (m_lockpend) m_locked = 1;
          m_lockpend = 0;
        end
      end
      if (start) begin
        m_active = 0; m_have = 0;
        if (!bz) begin m_lockpend = 0; foreach (m_stv[i]) m_stv[i] = 0; end
      end
      if (sel_vld && sel_type == IDT) begin
        e_ackv = 1; e_ack = !bz; m_active = !bz; m_rnw = sel_rnw;
        if (!bz) begin m_have = 0; m_lockpend = 0; end
      end else if (sel_vld) m_active = 0;
      if (addr_vld && m_active && !m_rnw) begin
        e_ackv = 1; e_ack = 1; m_ptr = addr[6:0]; m_islock = addr[10];
        foreach (m_stv[i]) m_stv[i] = 0;
      end
      if (wr_vld && m_active && !m_rnw) begin
        e_ackv = 1; e_ack = !m_locked;
        if (!m_locked) begin
          if (m_islock) begin
            if (!m_have) m_lockpend = wr_data[1];
          end else begin
            m_stg[m_ptr] = wr_data; m_stv[m_ptr] = 1; m_ptr = (m_ptr + 1) % 128;
          end
          m_have = 1;
        end
      end
      if (rd_req && m_active && m_rnw) begin
        e_rdv = 1;
        e_rd = (m_locked || !m_wr[m_ptr]) ? 255 : m_mem[m_ptr];
        m_ptr = (m_ptr + 1) % 128;
      end
      if (stop) begin
        if (m_active && !m_rnw && m_have) begin
          m_left = BUSY_CYC;
          foreach (m_stv[i]) if (m_stv[i]) begin
            pend_off.push_back(i); pend_dat.push_back(m_stg[i]);
          end
        end
        m_active = 0;
      end
    end
  end

  // compare the model against the ports on every clock
  always @(negedge clk) begin
    if (!rst && m_go) begin
      check({cur, " ack_vld"}, ack_vld, e_ackv);
      if (e_ackv) check({cur, " ack"}, ack, e_ack);
      check({cur, " rd_vld"}, rd_vld, e_rdv);
      if (e_rdv) check({cur, " rd_data"}, rd_data, e_rd);
      check({cur, " busy"}, busy, m_left > 0);
      check({cur, " locked"}, locked, m_locked);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic ev_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask
  task automatic ev_stop();
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask
  task automatic ev_sel(logic [3:0] t, logic r, output logic av, output logic a);
    @(negedge clk); sel_vld = 1; sel_type = t; sel_rnw = r;
    @(negedge clk); sel_vld = 0; av = ack_vld; a = ack;
  endtask
  task automatic ev_addr(logic [15:0] v, output logic a);
    @(negedge clk); addr_vld = 1; addr = v;
    @(negedge clk); addr_vld = 0; a = ack_vld & ack;
  endtask
  task automatic ev_wr(logic [7:0] d, output logic a);
    @(negedge clk); wr_vld = 1; wr_data = d;
    @(negedge clk); wr_vld = 0; a = ack_vld & ack;
  endtask
  task automatic ev_rd(output logic [7:0] d);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0; d = rd_data;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask
  task automatic open_read(logic [15:0] a16);
    logic av, a;
    ev_start(); ev_sel(IDT, 0, av, a); ev_addr(a16, a);
    ev_start(); ev_sel(IDT, 1, av, a);
  endtask

  // watchdog
  initial begin
    #(60000 * 5);
    fails++;
    $display("FAIL R- watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic av, a;
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R9: reset state
    cur = "R9";
    check("R9 busy after reset", busy, 0);
    check("R9 locked after reset", locked, 0);
    open_read(16'h0005);
    ev_rd(d); check("R9 fresh byte", d, 8'hFF);
    ev_stop();

    // R1: foreign type ignored, ID type acknowledged
    cur = "R1";
    ev_start(); ev_sel(4'hA, 0, av, a);
    check("R1 foreign type no ack_vld", av, 0);
    ev_start(); ev_sel(IDT, 0, av, a);
    check("R1 id select ack", av & a, 1);
    ev_stop();

    // R3: page write with upper address bits set, wrapping past 127
    cur = "R3";
    ev_start(); ev_sel(IDT, 0, av, a); ev_addr(16'hF87C, a);
    for (int i = 0; i < 6; i++) begin
      ev_wr(8'h11 * (i + 1), a); check("R3 data ack", a, 1);
    end
    ev_stop();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R3 busy length", n, BUSY_CYC);

    // R8: random read from a differently-padded address, wrap 127->0
    cur = "R8";
    open_read(16'h807C);
    for (int i = 0; i < 6; i++) begin
      ev_rd(d); check("R8 readback", d, 8'h11 * (i + 1));
    end
    ev_rd(d); check("R8 unwritten after wrap", d, 8'hFF);
    ev_stop();

    // R4: Start before Stop abandons the write
    cur = "R4";
    ev_start(); ev_sel(IDT, 0, av, a); ev_addr(16'h0010, a);
    ev_wr(8'hAB, a); check("R4 data ack", a, 1);
    ev_start();
    check("R4 no busy after abort", busy, 0);
    open_read(16'h0010);
    ev_rd(d); check("R4 not written", d, 8'hFF);
    ev_stop();

    // R11: probe while unlocked
    cur = "R11";
    ev_start(); ev_sel(IDT, 0, av, a); ev_addr(16'h0400, a);
    ev_wr(8'h02, a); check("R11 probe ack unlocked", a, 1);
    ev_start();
    repeat (2) @(negedge clk);
    check("R11 probe leaves lock clear", locked, 0);
    check("R11 probe no busy", busy, 0);

    // R5: lock command with bit1 = 0 does not lock; R2 select during busy
    cur = "R5";
    ev_start(); ev_sel(IDT, 0, av, a); ev_addr(16'h0400, a);
    ev_wr(8'hFD, a); check("R5 lock byte ack", a, 1);
    ev_stop();
    cur = "R2";
    ev_start(); ev_sel(IDT, 0, av, a);
    check("R2 busy select ack_vld", av, 1);
    check("R2 busy select nack", a, 0);
    ev_sel(IDT, 1, av, a);
    ev_rd(d);
    check("R2 no read while busy", rd_vld, 0);
    ev_stop();
    wait_idle();
    cur = "R5";
    check("R5 bit1 clear no lock", locked, 0);

    // R5: real lock, takes effect only after busy
    ev_start(); ev_sel(IDT, 0, av, a); ev_addr(16'h0C00, a);
    ev_wr(8'h02, a); check("R5 lock cmd ack", a, 1);
    ev_stop();
    check("R5 not locked during busy", locked, 0);
    wait_idle();
    check("R5 locked after busy", locked, 1);

    // R10, R6: locked write
    cur = "R6";
    ev_start(); ev_sel(IDT, 0, av, a); check("R6 select ack when locked", a, 1);
    ev_addr(16'h0003, a); check("R10 address ack when locked", a, 1);
    ev_wr(8'h99, a); check("R6 data nack when locked", a, 0);
    ev_stop();
    check("R6 no busy when locked", busy, 0);

    // R11: probe while locked
    cur = "R11";
    ev_start(); ev_sel(IDT, 0, av, a); ev_addr(16'h0400, a);
    ev_wr(8'h02, a); check("R11 probe nack locked", a, 0);
    ev_start();

    // R7: locked reads are all ones
    cur = "R7";
    open_read(16'h007C);
    ev_rd(d); check("R7 locked read", d, 8'hFF);
    ev_rd(d); check("R7 locked read next", d, 8'hFF);
    ev_stop();
    check("R6 lock stays set", locked, 1);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule